// File: doc/BRIEF.md
# Ethernet Collision Backoff Timer

After a collision on a half-duplex Ethernet link, the transmitter has to stay silent for a random number of slot times before it tries again. This block picks that number and times the wait. A 20-bit linear feedback shift register runs freely on the bit-time enable. On a collision strobe the block works out how many low register bits to use, takes them as the wait value `r`, and counts `r` down by one per slot time. When the count is used up it raises a one-cycle done pulse.

The number of bits used depends on two inputs. The first is the exponent, which grows with the frame's retry count and stops growing at ten. The second is a 2-bit aggressiveness setting that caps the exponent at a lower value. The cap lets software make the backoff less random or shorter than standard truncated binary exponential backoff.

The block runs on the system clock. The bit-time enable marks each bit time. A slot time is `SLOT_BITS` bit-time enables, 512 by default.

Top module: `collision_backoff_timer`

## Requirements
- R1: The random source is a 20-bit register. Reset loads it with `LFSR_SEED` (default 20'h00001). On every clock edge where `bit_en` is high it moves to `{q[18:0], q[19]^q[16]}`. It never holds zero.
- R2: The exponent K is the retry count `retry_cnt`, limited to 10. Counts of 10 and above give K = 10.
- R3: The cap is set by `bo_limit`: 2'b00 allows 10 bits, 2'b01 allows 8, 2'b10 allows 4 and 2'b11 allows 1.
- R4: The number of bits used is the smaller of K and the cap. On the clock edge where `coll_strobe` is high, `slots_left` loads the random register's low bits under that mask. The register value used is the one held just before that edge.
- R5: While busy, `slots_left` falls by exactly one after every `SLOT_BITS` bit-time enables.
- R6: `done` rises exactly `r*SLOT_BITS + 1` bit-time enables after the collision strobe. It is high for one clock cycle.
- R7: A sampled value of zero gives `done` on the first bit-time enable after the strobe.
- R8: `busy` rises on the clock edge after the strobe. It stays high until the edge on which `done` rises, and falls on that edge.
- R9: A collision strobe while busy restarts the wait. It loads a fresh sample and restarts the slot phase.
- R10: Reset leaves `busy`, `done` and `slots_left` at zero.
- R11: While `bit_en` is low, the wait makes no progress: `slots_left`, `busy` and the absence of `done` all hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle enable per bit time |
| coll_strobe | input | 1 | Collision detected, one clock cycle |
| retry_cnt | input | RETRY_W | Retry number of the current attempt |
| bo_limit | input | 2 | Backoff exponent cap setting |
| busy | output | 1 | Backoff wait in progress |
| done | output | 1 | One-cycle pulse at the end of the wait |
| slots_left | output | 10 | Slot times still to wait |

## Verification
On every cycle, the assertions check the following:
- `busy` follows the strobe.
- `done` lasts one cycle and ends `busy`.
- The random register never holds zero.
- A fresh sample stays inside its mask.
- The slot count only ever falls by one.
- Nothing moves while the bit-time enable is low.

Other properties can only be shown by the bench's scenarios, which mirror the random register on their own:
- Each sample equals exactly the masked register bits for a given retry count and cap.
- The total wait comes to exactly `r*SLOT_BITS + 1` enables, whether the enables arrive every cycle or only now and then.
- A mid-wait restart reloads the count.

// File: rtl/backoff_pkg.sv
package backoff_pkg;
  localparam int MAX_EXP = 10;

  // Bit cap chosen by the 2-bit aggressiveness setting
  function automatic int cap_bits(input logic [1:0] lim);
    case (lim)
      2'b00:   return MAX_EXP;
      2'b01:   return 8;
      2'b10:   return 4;
      default: return 1;
    endcase
  endfunction

  // Effective bit count: min(min(retry, MAX_EXP), cap)
  function automatic int exp_bits(input int retry, input logic [1:0] lim);
    int k;
    int c;
    k = (retry > MAX_EXP) ? MAX_EXP : retry;
    c = cap_bits(lim);
    return (k < c) ? k : c;
  endfunction
endpackage

// File: rtl/bo_lfsr.sv
module bo_lfsr #(
  parameter int W      = 20,
  parameter int TAP_A  = 20,
  parameter int TAP_B  = 17,
  parameter logic [W-1:0] SEED = 20'h00001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);
  logic [W-1:0] q;
  logic         fb;

  assign fb    = q[TAP_A-1] ^ q[TAP_B-1];
  assign state = q;

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= SEED;
    else if (step) q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/bo_exp_sel.sv
module bo_exp_sel #(
  parameter int RETRY_W = 5,
  parameter int CNT_W   = 10,
  parameter int LFSR_W  = 20
) (
  input  logic [RETRY_W-1:0] retry,
  input  logic [1:0]         limit,
  input  logic [LFSR_W-1:0]  rnd,
  output logic [CNT_W-1:0]   mask,
  output logic [CNT_W-1:0]   sample
);
  import backoff_pkg::*;

  int eff;
  assign eff = exp_bits(int'(retry), limit);

  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask[i] = (eff > i);
  end

  assign sample = rnd[CNT_W-1:0] & mask;
endmodule

// File: rtl/bo_slot_timer.sv
module bo_slot_timer #(
  parameter int CNT_W     = 10,
  parameter int SLOT_BITS = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] slots,
  output logic             slot_tick
);
  localparam int PHASE_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
  localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(SLOT_BITS - 1);

  logic [PHASE_W-1:0] phase;
  logic               finish;

  assign finish    = busy && bit_en && (slots == '0);
  assign slot_tick = busy && bit_en && (slots != '0) && (phase == PHASE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      slots <= '0;
      phase <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        slots <= load_val;
        phase <= '0;
      end else if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (slot_tick) begin
        phase <= '0;
        slots <= slots - CNT_W'(1);
      end else if (busy && bit_en) begin
        phase <= phase + PHASE_W'(1);
      end
    end
  end
endmodule

// File: rtl/collision_backoff_timer.sv
module collision_backoff_timer #(
  parameter int RETRY_W   = 5,
  parameter int SLOT_BITS = 512,
  parameter int LFSR_W    = 20,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 20'h00001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               coll_strobe,
  input  logic [RETRY_W-1:0] retry_cnt,
  input  logic [1:0]         bo_limit,
  output logic               busy,
  output logic               done,
  output logic [9:0]         slots_left
);
  localparam int CNT_W = backoff_pkg::MAX_EXP;

  logic [LFSR_W-1:0] lfsr_state;
  logic [CNT_W-1:0]  sample_mask;
  logic [CNT_W-1:0]  sample_val;
  logic              slot_tick;

  bo_lfsr #(.W(LFSR_W), .TAP_A(20), .TAP_B(17), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(bit_en), .state(lfsr_state)
  );

  bo_exp_sel #(.RETRY_W(RETRY_W), .CNT_W(CNT_W), .LFSR_W(LFSR_W)) u_sel (
    .retry(retry_cnt), .limit(bo_limit), .rnd(lfsr_state),
    .mask(sample_mask), .sample(sample_val)
  );

  bo_slot_timer #(.CNT_W(CNT_W), .SLOT_BITS(SLOT_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(coll_strobe),
    .load_val(sample_val), .busy(busy), .done(done), .slots(slots_left),
    .slot_tick(slot_tick)
  );
endmodule

// File: rtl/backoff_timer_checker.sv
module backoff_timer_checker #(
  parameter int CNT_W  = 10,
  parameter int LFSR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic              coll_strobe,
  input logic              busy,
  input logic              done,
  input logic [CNT_W-1:0]  slots_left,
  input logic [CNT_W-1:0]  sample_mask,
  input logic [LFSR_W-1:0] lfsr_state
);
  // R1
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_state != '0);
  // R8
  busy_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coll_strobe |=> busy);
  // R8
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4
  sample_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coll_strobe |=> ((slots_left & ~$past(sample_mask)) == '0));
  // R5
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !coll_strobe) |=>
      (slots_left == $past(slots_left) || slots_left == $past(slots_left) - CNT_W'(1)));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_en && !coll_strobe) |=> ($stable(slots_left) && busy && !done));
endmodule

bind collision_backoff_timer backoff_timer_checker #(.CNT_W(CNT_W), .LFSR_W(LFSR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .coll_strobe(coll_strobe),
  .busy(busy), .done(done), .slots_left(slots_left),
  .sample_mask(sample_mask), .lfsr_state(lfsr_state)
);

// File: tb/collision_backoff_timer_test.sv
module collision_backoff_timer_test;
  localparam int S = 8;
  localparam int WATCHDOG = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       coll_strobe = 1'b0;
  logic [4:0] retry_cnt = '0;
  logic [1:0] bo_limit = '0;
  logic       busy, done;
  logic [9:0] slots_left;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  collision_backoff_timer #(.SLOT_BITS(S)) uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .coll_strobe(coll_strobe),
    .retry_cnt(retry_cnt), .bo_limit(bo_limit),
    .busy(busy), .done(done), .slots_left(slots_left)
  );

  // Bench-side mirror of the random register, from R1
  logic [19:0] m;
  always_ff @(posedge clk) begin
    if (!rst_n)      m <= 20'h00001;
    else if (bit_en) m <= {m[18:0], m[19] ^ m[16]};
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act %0d cycles exp < %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [4:0] retry;
    logic [1:0] lim;
    logic [3:0] bits;    // expected effective bit count (R2, R3, R4)
    logic [1:0] period;  // bit_en every period cycles
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{5'd3,  2'b00, 4'd3,  2'd1},
    '{5'd12, 2'b00, 4'd10, 2'd1},
    '{5'd12, 2'b10, 4'd4,  2'd1},
    '{5'd10, 2'b01, 4'd8,  2'd1},
    '{5'd7,  2'b01, 4'd7,  2'd2},
    '{5'd9,  2'b11, 4'd1,  2'd1},
    '{5'd0,  2'b00, 4'd0,  2'd1},
    '{5'd2,  2'b10, 4'd2,  2'd3},
    '{5'd20, 2'b11, 4'd1,  2'd1},
    '{5'd5,  2'b10, 4'd4,  2'd1},
    '{5'd31, 2'b01, 4'd8,  2'd1},
    '{5'd11, 2'b00, 4'd10, 2'd1}
  };

  // Apply a collision strobe, return expected sample; checks load (R4, R8)
  task automatic strike(input logic [4:0] n, input logic [1:0] lim,
                        input int bits, output int exp_r);
    @(negedge clk);
    retry_cnt   = n;
    bo_limit    = lim;
    bit_en      = 1'b0;
    coll_strobe = 1'b1;
    exp_r = int'(m) & ((1 << bits) - 1);
    @(negedge clk);
    coll_strobe = 1'b0;
    chk(busy == 1'b1, "R8 busy after strobe", int'(busy), 1);
    chk(int'(slots_left) == exp_r, "R4 sampled slots", int'(slots_left), exp_r);
  endtask

  // Run the wait to its end; checks count, stepping and busy drop (R5, R6, R8)
  task automatic finish_wait(input int exp_r, input int period, input string tag);
    int ens = 0;
    int cyc = 0;
    bit step_ok = 1'b1;
    int bad_act = 0;
    int bad_exp = 0;
    while (!done && cyc < 40000) begin
      if (int'(slots_left) != exp_r - ens / S && step_ok) begin
        step_ok = 1'b0;
        bad_act = int'(slots_left);
        bad_exp = exp_r - ens / S;
      end
      bit_en = ((cyc % period) == 0);
      if (bit_en) ens++;
      cyc++;
      @(negedge clk);
    end
    bit_en = 1'b0;
    chk(step_ok, "R5 slot countdown", bad_act, bad_exp);
    chk(done && ens == exp_r * S + 1, {"R6 enables to done ", tag}, ens, exp_r * S + 1);
    chk(busy == 1'b0, "R8 busy low at done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", int'(done), 0);
  endtask

  initial begin
    int r;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy == 1'b0 && done == 1'b0, "R10 reset busy/done", int'({busy, done}), 0);
    chk(slots_left == '0, "R10 reset slots", int'(slots_left), 0);
    rst_n = 1'b1;

    // Table walk: R2, R3, R4, R5, R6, R8, R1 (mirror match)
    foreach (VECS[i]) begin
      for (int k = 0; k < i + 3; k++) begin
        @(negedge clk);
        bit_en = 1'b1;
      end
      @(negedge clk);
      bit_en = 1'b0;
      strike(VECS[i].retry, VECS[i].lim, int'(VECS[i].bits), r);
      chk(r < (1 << VECS[i].bits) || r == 0, "R1 sample range", r, (1 << VECS[i].bits) - 1);
      finish_wait(r, int'(VECS[i].period), $sformatf("vec%0d", i));
    end

    // R7: retry 0 gives zero wait, done on first enable
    strike(5'd0, 2'b01, 0, r);
    chk(slots_left == '0, "R7 zero sample", int'(slots_left), 0);
    @(negedge clk);
    chk(done == 1'b0, "R7 no done without enable", int'(done), 0);
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    chk(done == 1'b1, "R7 done on first enable", int'(done), 1);

    // R11: hold with bit_en low
    repeat (5) begin @(negedge clk); bit_en = 1'b1; end
    strike(5'd12, 2'b00, 10, r);
    begin
      bit hold_ok = 1'b1;
      repeat (20) begin
        @(negedge clk);
        if (!busy || done || int'(slots_left) != r) hold_ok = 1'b0;
      end
      chk(hold_ok, "R11 no progress without enable", int'(slots_left), r);
    end
    finish_wait(r, 1, "after hold");

    // R9: restart while busy
    repeat (7) begin @(negedge clk); bit_en = 1'b1; end
    strike(5'd10, 2'b01, 8, r);
    repeat (S + 3) begin @(negedge clk); bit_en = 1'b1; end
    @(negedge clk);
    bit_en = 1'b0;
    strike(5'd4, 2'b10, 4, r);
    chk(busy == 1'b1, "R9 busy kept on restart", int'(busy), 1);
    finish_wait(r, 1, "R9 restart");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule